// File: doc/BRIEF.md
# Dual-Synthesizer Divider Configuration Loader

This block takes a three-wire serial stream and turns it into the divider settings of a two-channel frequency synthesizer. A 21-bit word is shifted in, most significant bit first, on rising edges of the serial clock while the load strobe is low. The two bits shifted in last form an address. The rising edge of the load strobe copies the remaining 19 bits into the holding register that the address selects. The holding registers drive the reference, main, swallow and fraction values of the two channels.

One holding register also carries a select bit for the shared output pin. When that bit is set, the pin repeats the top bit of the shift register, updated on the falling clock edge, so that several loaders can share one data line as a daisy chain. When the bit is clear, the pin stays low. The clock runs freely. Shifting is frozen for as long as the load strobe is high, and the load itself is detected from the strobe as sampled on rising clock edges.

Top module: `synth_cfg_loader`

## Requirements
- R1: A synchronous active-high reset clears the shift register, every holding register and the output select. The shared output is then low.
- R2: On each rising clock edge with the load strobe low, the shift register moves up one place and takes the data input into bit 0. The first bit sent therefore ends up in bit 20, and the last two bits sent end up in bits [1:0] as the address.
- R3: A load with address 0 writes channel 1: main count from word bits [20:12], swallow count from [11:7], fraction from [6:2].
- R4: A load with address 1 writes channel 2: main count from [20:12], swallow count from [10:7], fraction from [6:2]. Bit 11 is ignored.
- R5: A load with address 2 writes the reference values and the output select: channel 1 reference from [20:12], channel 2 reference from [11:3], output select from bit 2 (1 = serial data out, 0 = constant low).
- R6: A load with address 3 changes no holding register.
- R7: A load happens only on the first rising clock edge at which the strobe is seen high after being seen low. Holding registers never change otherwise. While the strobe stays high, the shift register keeps its contents.
- R8: On each falling clock edge, the shared output takes bit 20 of the shift register when the output select is 1, and takes 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous reset, active high |
| sdata | input | 1 | Serial data, MSB first |
| le | input | 1 | Load strobe; low while shifting |
| ref1_o | output | 9 | Channel 1 reference divide value |
| main1_o | output | 9 | Channel 1 main count |
| swl1_o | output | 5 | Channel 1 swallow count |
| frac1_o | output | 5 | Channel 1 fraction |
| ref2_o | output | 9 | Channel 2 reference divide value |
| main2_o | output | 9 | Channel 2 main count |
| swl2_o | output | 4 | Channel 2 swallow count |
| frac2_o | output | 5 | Channel 2 fraction |
| chain_o | output | 1 | Shared output: serial data out or constant low |

## Verification
The hardest state to observe from the ports is the shift register itself, because it is visible only through the shared output, and only after a reference-register load has set the output select. The stimulus therefore first loads address 2 with the select set. It then sends further words, so that every bit of the previous word can be seen leaving through the output in MSB-first order. While the strobe is held high and the data line toggles, the output must not move. Random words with random addresses, including some that turn the select off again, are mixed with directed all-ones words to address 3 and to channel 2 with the ignored bit set.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  typedef enum logic [1:0] {
    ADR_CH1   = 2'd0,
    ADR_CH2   = 2'd1,
    ADR_REF   = 2'd2,
    ADR_SPARE = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdata,
  input  logic         le,
  output logic [W-1:0] word,
  output logic         load
);
  logic le_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      le_q <= 1'b1;  // no spurious load if the strobe is high at reset release
    end else begin
      le_q <= le;
      if (!le) word <= {word[W-2:0], sdata};
    end
  end

  assign load = le & ~le_q;
endmodule

// File: rtl/cfg_chan.sv
module cfg_chan
  import sercfg_pkg::*;
#(
  parameter int        MW      = 9,
  parameter int        SW      = 5,
  parameter int        FW      = 5,
  parameter cfg_addr_e MY_ADDR = ADR_CH1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  cfg_addr_e     addr,
  input  logic [MW-1:0] main_in,
  input  logic [SW-1:0] swl_in,
  input  logic [FW-1:0] frac_in,
  output logic [MW-1:0] main_q,
  output logic [SW-1:0] swl_q,
  output logic [FW-1:0] frac_q
);
  logic wr;
  assign wr = load && (addr == MY_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      swl_q  <= '0;
      frac_q <= '0;
    end else if (wr) begin
      main_q <= main_in;
      swl_q  <= swl_in;
      frac_q <= frac_in;
    end
  end
endmodule

// File: rtl/cfg_refsel.sv
module cfg_refsel
  import sercfg_pkg::*;
#(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  cfg_addr_e     addr,
  input  logic [RW-1:0] ref1_in,
  input  logic [RW-1:0] ref2_in,
  input  logic          sel_in,
  output logic [RW-1:0] ref1_q,
  output logic [RW-1:0] ref2_q,
  output logic          sel_q
);
  logic wr;
  assign wr = load && (addr == ADR_REF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref1_q <= '0;
      ref2_q <= '0;
      sel_q  <= 1'b0;
    end else if (wr) begin
      ref1_q <= ref1_in;
      ref2_q <= ref2_in;
      sel_q  <= sel_in;
    end
  end
endmodule

// File: rtl/cfg_chain.sv
module cfg_chain (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic top_bit,
  output logic chain_q
);
  // falling-edge update gives the next device half a cycle of setup
  always_ff @(negedge clk) begin
    if (rst) chain_q <= 1'b0;
    else     chain_q <= sel & top_bit;
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import sercfg_pkg::*;
#(
  parameter int WORD_W = 21,
  parameter int REF_W  = 9,
  parameter int MAIN_W = 9,
  parameter int SWL1_W = 5,
  parameter int SWL2_W = 4,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata,
  input  logic              le,
  output logic [REF_W-1:0]  ref1_o,
  output logic [MAIN_W-1:0] main1_o,
  output logic [SWL1_W-1:0] swl1_o,
  output logic [FRAC_W-1:0] frac1_o,
  output logic [REF_W-1:0]  ref2_o,
  output logic [MAIN_W-1:0] main2_o,
  output logic [SWL2_W-1:0] swl2_o,
  output logic [FRAC_W-1:0] frac2_o,
  output logic              chain_o
);
  localparam int ADDR_W = 2;
  localparam int DATA_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0] sr_word;
  logic [DATA_W-1:0] dat;
  logic              load_p;
  logic              sel_q;
  cfg_addr_e         addr;

  assign dat  = sr_word[WORD_W-1:ADDR_W];
  assign addr = cfg_addr_e'(sr_word[ADDR_W-1:0]);

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sdata(sdata), .le(le),
    .word(sr_word), .load(load_p)
  );

  cfg_chan #(.MW(MAIN_W), .SW(SWL1_W), .FW(FRAC_W), .MY_ADDR(ADR_CH1)) u_ch1 (
    .clk(clk), .rst(rst), .load(load_p), .addr(addr),
    .main_in(dat[DATA_W-1 -: MAIN_W]),
    .swl_in (dat[FRAC_W +: SWL1_W]),
    .frac_in(dat[0 +: FRAC_W]),
    .main_q(main1_o), .swl_q(swl1_o), .frac_q(frac1_o)
  );

  cfg_chan #(.MW(MAIN_W), .SW(SWL2_W), .FW(FRAC_W), .MY_ADDR(ADR_CH2)) u_ch2 (
    .clk(clk), .rst(rst), .load(load_p), .addr(addr),
    .main_in(dat[DATA_W-1 -: MAIN_W]),
    .swl_in (dat[FRAC_W +: SWL2_W]),
    .frac_in(dat[0 +: FRAC_W]),
    .main_q(main2_o), .swl_q(swl2_o), .frac_q(frac2_o)
  );

  cfg_refsel #(.RW(REF_W)) u_ref (
    .clk(clk), .rst(rst), .load(load_p), .addr(addr),
    .ref1_in(dat[DATA_W-1 -: REF_W]),
    .ref2_in(dat[1 +: REF_W]),
    .sel_in (dat[0]),
    .ref1_q(ref1_o), .ref2_q(ref2_o), .sel_q(sel_q)
  );

  cfg_chain u_chain (
    .clk(clk), .rst(rst), .sel(sel_q), .top_bit(sr_word[WORD_W-1]),
    .chain_q(chain_o)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int WORD_W = 21,
  parameter int REF_W  = 9,
  parameter int MAIN_W = 9,
  parameter int SWL1_W = 5,
  parameter int SWL2_W = 4,
  parameter int FRAC_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sdata,
  input logic              le,
  input logic [WORD_W-1:0] word,
  input logic              load,
  input logic              sel,
  input logic [REF_W-1:0]  ref1,
  input logic [MAIN_W-1:0] main1,
  input logic [SWL1_W-1:0] swl1,
  input logic [FRAC_W-1:0] frac1,
  input logic [REF_W-1:0]  ref2,
  input logic [MAIN_W-1:0] main2,
  input logic [SWL2_W-1:0] swl2,
  input logic [FRAC_W-1:0] frac2,
  input logic              chain
);
  logic [2*REF_W+2*MAIN_W+SWL1_W+SWL2_W+2*FRAC_W:0] all_f;
  assign all_f = {ref1, main1, swl1, frac1, ref2, main2, swl2, frac2, sel};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (all_f == '0 && word == '0));

  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    !le |=> word[0] == $past(sdata));

  a_r3_ch1_write: assert property (@(posedge clk) disable iff (rst)
    (load && word[1:0] == 2'd0) |=> main1 == $past(word[WORD_W-1 -: MAIN_W]));

  a_r5_sel_write: assert property (@(posedge clk) disable iff (rst)
    (load && word[1:0] == 2'd2) |=> sel == $past(word[2]));

  a_r6_spare_addr: assert property (@(posedge clk) disable iff (rst)
    (load && word[1:0] == 2'd3) |=> $stable(all_f));

  a_r7_no_load_stable: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(all_f));

  a_r7_frozen_shift: assert property (@(posedge clk) disable iff (rst)
    le |=> $stable(word));

  a_r8_chain_out: assert property (@(posedge clk) disable iff (rst)
    chain == (sel & word[WORD_W-1]));
endmodule

bind synth_cfg_loader cfg_loader_chk #(
  .WORD_W(WORD_W), .REF_W(REF_W), .MAIN_W(MAIN_W),
  .SWL1_W(SWL1_W), .SWL2_W(SWL2_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst(rst), .sdata(sdata), .le(le),
  .word(sr_word), .load(load_p), .sel(sel_q),
  .ref1(ref1_o), .main1(main1_o), .swl1(swl1_o), .frac1(frac1_o),
  .ref2(ref2_o), .main2(main2_o), .swl2(swl2_o), .frac2(frac2_o),
  .chain(chain_o)
);

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
  logic clk = 1'b0;
  logic rst, sdata, le;
  logic [8:0] ref1_o, main1_o, ref2_o, main2_o;
  logic [4:0] swl1_o, frac1_o, frac2_o;
  logic [3:0] swl2_o;
  logic       chain_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [8:0]  e_r1, e_m1, e_r2, e_m2;
  logic [4:0]  e_s1, e_f1, e_f2;
  logic [3:0]  e_s2;
  logic        e_sel;
  logic [20:0] model_sr;

  always #2 clk = ~clk;

  synth_cfg_loader u0 (
    .clk(clk), .rst(rst), .sdata(sdata), .le(le),
    .ref1_o(ref1_o), .main1_o(main1_o), .swl1_o(swl1_o), .frac1_o(frac1_o),
    .ref2_o(ref2_o), .main2_o(main2_o), .swl2_o(swl2_o), .frac2_o(frac2_o),
    .chain_o(chain_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_fields(input string req);
    chk(req, "ref1",  int'(ref1_o),  int'(e_r1));
    chk(req, "main1", int'(main1_o), int'(e_m1));
    chk(req, "swl1",  int'(swl1_o),  int'(e_s1));
    chk(req, "frac1", int'(frac1_o), int'(e_f1));
    chk(req, "ref2",  int'(ref2_o),  int'(e_r2));
    chk(req, "main2", int'(main2_o), int'(e_m2));
    chk(req, "swl2",  int'(swl2_o),  int'(e_s2));
    chk(req, "frac2", int'(frac2_o), int'(e_f2));
  endtask

  // R2 shows through the chain only when select is on; R8 otherwise
  task automatic chk_chain();
    chk(e_sel ? "R2" : "R8", "chain", int'(chain_o), int'(e_sel & model_sr[20]));
  endtask

  function automatic string apply_load(input logic [20:0] w);
    case (w[1:0])
      2'd0: begin e_m1 = w[20:12]; e_s1 = w[11:7]; e_f1 = w[6:2]; return "R3"; end
      2'd1: begin e_m2 = w[20:12]; e_s2 = w[10:7]; e_f2 = w[6:2]; return "R4"; end
      2'd2: begin e_r1 = w[20:12]; e_r2 = w[11:3]; e_sel = w[2]; return "R5"; end
      default: return "R6";
    endcase
  endfunction

  task automatic send_word(input logic [20:0] w);
    string req;
    for (int i = 20; i >= 0; i--) begin
      @(negedge clk); #1;
      chk_chain();
      if (i == 10) check_fields("R7");
      sdata = w[i];
      le = 1'b0;
      model_sr = {model_sr[19:0], w[i]};
    end
    @(negedge clk); #1;
    chk_chain();
    le = 1'b1;
    @(negedge clk); #1;
    req = apply_load(w);
    check_fields(req);
    chk("R8", "chain after load", int'(chain_o), int'(e_sel & model_sr[20]));
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    e_r1 = '0; e_m1 = '0; e_s1 = '0; e_f1 = '0;
    e_r2 = '0; e_m2 = '0; e_s2 = '0; e_f2 = '0;
    e_sel = 1'b0; model_sr = '0;
    @(negedge clk); #1;
    check_fields("R1");
    chk("R1", "chain", int'(chain_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [20:0] w;
    int unsigned seed_dummy;
    rst = 1'b1; le = 1'b1; sdata = 1'b0;
    seed_dummy = $urandom(32'h5EED_1234);
    do_reset();

    // R5: reference load with select on, ref2 pattern
    send_word({9'h1FF, 9'h0AB, 1'b1, 2'd2});
    // R3: channel 1 with all-ones fields
    send_word({9'h1FF, 5'h1F, 5'h1F, 2'd0});
    // R4: channel 2 with bit 11 set, must be dropped
    send_word({9'h123, 1'b1, 4'h5, 5'h0A, 2'd1});
    // R6: spare address, all ones
    send_word({19'h7FFFF, 2'd3});
    // R3: mixed values
    send_word({9'h0C3, 5'h11, 5'h06, 2'd0});

    // R7: strobe held high, data toggles, nothing may move
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      chk("R7", "chain frozen", int'(chain_o), int'(e_sel & model_sr[20]));
      sdata = ~sdata;
    end
    check_fields("R7");

    // random words, random addresses
    for (int n = 0; n < 60; n++) begin
      w = 21'($urandom);
      send_word(w);
    end

    // R5: select off, then chain must stay low while shifting
    send_word({9'h055, 9'h1AA, 1'b0, 2'd2});
    send_word(21'h1FFFFC);

    do_reset();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule